// File: doc/BRIEF.md
# Dual-Core Interrupt Status and Mask Unit

This block gathers level-type interrupt sources from a chip's peripherals and offers them to two processor cores. Every core sees the same raw source levels through a status view, and each core has its own bank of mask words. Each core gets one summary interrupt line. That line is high whenever at least one source is both pending and enabled in that core's mask. The source count is a parameter, either 32 or 64, and every register word holds 32 sources.

Configuration registers are reached through a request/response port with valid/ready handshakes. A narrow slice of the source vector can be taken over by an external-interrupt front end, so that those external lines appear as ordinary bits in the internal vector. If the second core's mask bank is configured away, that bank reads as zero, ignores writes, and its summary line stays low.

Register words are addressed as 32-bit word indices. For core `c` the region starts at `c*2*W`, where `W` is `NUM_SRC/32`. The first `W` words of a region are status and the next `W` words are mask. Inside either half, word `k` holds source group `k XOR (W-1)`. In 64-source mode this puts sources 63..32 at the lower address.

Top module: `intr_stat_mask`

## Requirements
- R1: After reset every mask word reads 0, both `irq_o` bits are 0, and `rsp_valid` is 0.
- R2: Reading status word `k` of either core returns sources `32*g+31 .. 32*g` with `g = k XOR (W-1)`, bit `i` of the word being source `32*g+i`. With 64 sources, word 0 holds sources 63..32 and word 1 holds sources 31..0. The returned values are the levels registered one clock earlier.
- R3: Each core's mask words are written and read back independently, using the same word-to-group mapping as R2. A write to one core's mask leaves the other core's mask unchanged.
- R4: `irq_o[c]` is the registered OR of (raw sources AND core `c` mask). It changes one rising edge after the edge that accepts a mask write. It changes two rising edges after a source input changes.
- R5: A write to any status word has no effect on read data or on `irq_o`.
- R6: Source bits `EXT_LO .. EXT_LO+EXT_CNT-1` take their levels from `ext_irq[0..EXT_CNT-1]`. The `src_level` bits at those positions are ignored.
- R7: With `HAS_CORE1 = 0`, core 1 mask words read 0, writes to them are ignored, and `irq_o[1]` stays 0.
- R8: A request is accepted when `req_valid && req_ready`. `req_ready` is low while a read response is held with `rsp_ready` low, and during that time `rsp_valid` and `rsp_rdata` stay stable. Only reads produce a response. It appears on the edge that accepts the read and is dropped on the first edge where `rsp_ready` is high.
- R9: With 32 sources, each region is one word: core 0 status at 0, core 0 mask at 1, core 1 status at 2, core 1 mask at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Level interrupt sources |
| ext_irq | input | EXT_CNT | Cascaded external interrupt levels |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address, AW = log2(4*NUM_SRC/32) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 2 | Summary interrupt per core (bit 0 = core 0) |

## Verification
Read data appears on the edge that accepts the read, so the bench samples it at the falling edge after that acceptance. A mask change reaches `irq_o` one edge after its write is accepted. The bench checks the line still holds its old value at the first falling edge and has its new value at the second. A source change takes two edges to reach `irq_o`, because the levels are registered before the summary, and the bench samples the old value after one edge and the new value after two. While a response is stalled, the response signals and `req_ready` are compared over several falling edges.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int WORD_BITS = 32;

  typedef enum logic {
    REGION_STATUS = 1'b0,
    REGION_MASK   = 1'b1
  } region_e;

  // Register word k holds source group k XOR (words-1).
  function automatic int group_of_word(int k, int words);
    return k ^ (words - 1);
  endfunction
endpackage

// File: rtl/isc_src_capture.sv
module isc_src_capture #(
  parameter int NUM_SRC = 64,
  parameter int EXT_LO  = 40,
  parameter int EXT_CNT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [EXT_CNT-1:0] ext_irq,
  output logic [NUM_SRC-1:0] raw_q
);
  logic [NUM_SRC-1:0] merged;

  // The cascade slice is fed from the external front end.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i >= EXT_LO && i < EXT_LO + EXT_CNT) begin : g_ext
      assign merged[i] = ext_irq[i - EXT_LO];
    end else begin : g_int
      assign merged[i] = src_level[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= merged;
  end
endmodule

// File: rtl/isc_mask_bank.sv
module isc_mask_bank #(
  parameter int NUM_SRC = 64,
  parameter bit PRESENT = 1'b1,
  localparam int WORDS  = NUM_SRC / isc_pkg::WORD_BITS,
  localparam int GW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [GW-1:0]      wr_grp,
  input  logic [31:0]        wr_data,
  output logic [NUM_SRC-1:0] mask
);
  if (PRESENT) begin : g_bank
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                              word_q <= '0;
        else if (wr_en && int'(wr_grp) == g)     word_q <= wr_data;
      end
      assign mask[g*32 +: 32] = word_q;
    end
  end else begin : g_absent
    logic unused_ok;
    assign unused_ok = &{1'b0, clk, rst_n, wr_en, wr_grp, wr_data};
    assign mask = '0;
  end
endmodule

// File: rtl/isc_summary.sv
module isc_summary #(
  parameter int NUM_SRC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     raw,
  input  logic [1:0][NUM_SRC-1:0] masks,
  output logic [1:0]             irq_q
);
  for (genvar c = 0; c < 2; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[c] <= 1'b0;
      else        irq_q[c] <= |(raw & masks[c]);
    end
  end
endmodule

// File: rtl/isc_regif.sv
module isc_regif #(
  parameter int NUM_SRC = 64,
  localparam int WORDS  = NUM_SRC / isc_pkg::WORD_BITS,
  localparam int GW     = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int AW     = $clog2(4 * WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_rdata,
  input  logic [NUM_SRC-1:0]      raw,
  input  logic [1:0][NUM_SRC-1:0] masks,
  output logic [1:0]              wr_en,
  output logic [GW-1:0]           wr_grp,
  output logic [31:0]             wr_data
);
  import isc_pkg::*;

  logic          accept;
  logic          core_sel;
  region_e       region;
  logic [GW-1:0] word_idx;
  logic [GW-1:0] grp;
  logic [31:0]   rd_val;

  // Address = {core, region, word}.
  assign core_sel = req_addr[AW-1];
  assign region   = region_e'(req_addr[AW-2]);

  if (WORDS > 1) begin : g_multi
    assign word_idx = req_addr[GW-1:0];
  end else begin : g_single
    logic unused_bit;
    assign unused_bit = req_addr[0];
    assign word_idx   = '0;
  end

  assign grp = GW'(group_of_word(int'(word_idx), WORDS));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (region == REGION_STATUS) rd_val = raw[int'(grp)*32 +: 32];
    else                         rd_val = masks[core_sel][int'(grp)*32 +: 32];
  end

  for (genvar c = 0; c < 2; c++) begin : g_wen
    assign wr_en[c] = accept && req_write && (region == REGION_MASK) && (core_sel == c[0]);
  end
  assign wr_grp  = grp;
  assign wr_data = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_stat_mask.sv
module intr_stat_mask #(
  parameter int NUM_SRC   = 64,
  parameter bit HAS_CORE1 = 1'b1,
  parameter int EXT_LO    = 40,
  parameter int EXT_CNT   = 6,
  localparam int WORDS    = NUM_SRC / isc_pkg::WORD_BITS,
  localparam int GW       = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int AW       = $clog2(4 * WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [EXT_CNT-1:0] ext_irq,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic [1:0]         irq_o
);
  logic [NUM_SRC-1:0]      raw;
  logic [1:0][NUM_SRC-1:0] masks;
  logic [1:0]              wr_en;
  logic [GW-1:0]           wr_grp;
  logic [31:0]             wr_data;

  isc_src_capture #(.NUM_SRC(NUM_SRC), .EXT_LO(EXT_LO), .EXT_CNT(EXT_CNT)) cap_i (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .ext_irq(ext_irq), .raw_q(raw)
  );

  isc_regif #(.NUM_SRC(NUM_SRC)) regif_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .raw(raw), .masks(masks),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_data(wr_data)
  );

  for (genvar c = 0; c < 2; c++) begin : g_bank
    isc_mask_bank #(.NUM_SRC(NUM_SRC), .PRESENT((c == 0) ? 1'b1 : HAS_CORE1)) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[c]), .wr_grp(wr_grp),
      .wr_data(wr_data), .mask(masks[c])
    );
  end

  isc_summary #(.NUM_SRC(NUM_SRC)) sum_i (
    .clk(clk), .rst_n(rst_n), .raw(raw), .masks(masks), .irq_q(irq_o)
  );
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int NUM_SRC   = 64,
  parameter bit HAS_CORE1 = 1'b1,
  parameter int EXT_CNT   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_level,
  input logic [EXT_CNT-1:0] ext_irq,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [31:0]        rsp_rdata,
  input logic [1:0]         irq_o
);
  // R1: summary lines are low when reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == 2'b00));

  // R4: with no source active for two samples, no summary line is high
  a_r4_no_source_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (src_level == '0 && ext_irq == '0) ##1 (src_level == '0 && ext_irq == '0)
      |=> (irq_o == 2'b00));

  // R8: a stalled response blocks new requests
  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R8: a stalled response stays put
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  if (!HAS_CORE1) begin : g_absent
    // R7: absent second bank never raises its line
    a_r7_core1_silent: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid || !rsp_valid |-> !irq_o[1]);
  end
endmodule

bind intr_stat_mask isc_checker #(.NUM_SRC(NUM_SRC), .HAS_CORE1(HAS_CORE1), .EXT_CNT(EXT_CNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_level(src_level), .ext_irq(ext_irq),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq_o(irq_o)
);

// File: tb/intr_stat_mask_tb.sv
module intr_stat_mask_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // wide instance: 64 sources, cascade bits 40..45
  logic [63:0] src = '0;
  logic [5:0]  ext = '0;
  logic        rv = 1'b0, rw = 1'b0, rr = 1'b1;
  logic [2:0]  ra = '0;
  logic [31:0] wd = '0;
  logic        rdy, vld;
  logic [31:0] rd;
  logic [1:0]  irq;

  // narrow instance: 32 sources, cascade bits 8..11, no second bank
  logic [31:0] n_src = '0;
  logic [3:0]  n_ext = '0;
  logic        n_rv = 1'b0, n_rw = 1'b0;
  logic [1:0]  n_ra = '0;
  logic [31:0] n_wd = '0;
  logic        n_rdy, n_vld;
  logic [31:0] n_rd;
  logic [1:0]  n_irq;

  intr_stat_mask dut_i (
    .clk(clk), .rst_n(rst_n), .src_level(src), .ext_irq(ext),
    .req_valid(rv), .req_ready(rdy), .req_write(rw), .req_addr(ra), .req_wdata(wd),
    .rsp_valid(vld), .rsp_ready(rr), .rsp_rdata(rd), .irq_o(irq)
  );

  intr_stat_mask #(.NUM_SRC(32), .HAS_CORE1(1'b0), .EXT_LO(8), .EXT_CNT(4)) dut32_i (
    .clk(clk), .rst_n(rst_n), .src_level(n_src), .ext_irq(n_ext),
    .req_valid(n_rv), .req_ready(n_rdy), .req_write(n_rw), .req_addr(n_ra), .req_wdata(n_wd),
    .rsp_valid(n_vld), .rsp_ready(1'b1), .rsp_rdata(n_rd), .irq_o(n_irq)
  );

  function automatic logic [63:0] raw64();
    return (src & ~(64'h3F << 40)) | (64'(ext) << 40);
  endfunction

  function automatic logic [31:0] raw32();
    return (n_src & ~(32'hF << 8)) | (32'(n_ext) << 8);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(bit nar, int addr, logic [31:0] d);
    @(negedge clk);
    if (nar) begin n_rv = 1; n_rw = 1; n_ra = 2'(addr); n_wd = d; end
    else     begin rv = 1; rw = 1; ra = 3'(addr); wd = d; end
    @(negedge clk);
    n_rv = 0; rv = 0; n_rw = 0; rw = 0;
  endtask

  task automatic bus_rd(bit nar, int addr, output logic [31:0] d);
    @(negedge clk);
    if (nar) begin n_rv = 1; n_rw = 0; n_ra = 2'(addr); end
    else     begin rv = 1; rw = 0; ra = 3'(addr); end
    @(negedge clk);
    n_rv = 0; rv = 0;
    d = nar ? n_rd : rd;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 rsp_valid", 64'(vld), 64'd0);
    bus_rd(0, 2, d); check("R1 core0 mask", 64'(d), 64'd0);
    bus_rd(0, 7, d); check("R1 core1 mask", 64'(d), 64'd0);
  endtask

  task automatic t_word_order();
    logic [31:0] d;
    logic [63:0] r;
    @(negedge clk); src = 64'h1234_5678_9ABC_DEF0; ext = '0;
    @(negedge clk); @(negedge clk);
    r = raw64();
    bus_rd(0, 0, d); check("R2 word0 high group", 64'(d), 64'(r[63:32]));
    bus_rd(0, 1, d); check("R2 word1 low group", 64'(d), 64'(r[31:0]));
    bus_rd(0, 4, d); check("R2 core1 word0", 64'(d), 64'(r[63:32]));
    check("R2 high value", 64'(r[63:32]), 64'h1234_4078);
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    @(negedge clk); src = 64'h0000_3F00_0000_0000; ext = '0;
    @(negedge clk); @(negedge clk);
    bus_rd(0, 0, d); check("R6 src slice ignored", 64'(d), 64'd0);
    @(negedge clk); ext = 6'b100101;
    @(negedge clk); @(negedge clk);
    bus_rd(0, 0, d); check("R6 ext feeds slice", 64'(d), 64'h2500);
  endtask

  task automatic t_mask_indep();
    logic [31:0] d;
    @(negedge clk); src = '0; ext = '0;
    bus_wr(0, 2, 32'h0000_0100);
    bus_wr(0, 6, 32'h0000_0000);
    bus_rd(0, 2, d); check("R3 core0 mask readback", 64'(d), 64'h100);
    bus_rd(0, 6, d); check("R3 core1 mask untouched", 64'(d), 64'h0);
    @(negedge clk); ext = 6'b000001;
    @(negedge clk); check("R4 src latency early", 64'(irq), 64'd0);
    @(negedge clk); check("R4 src latency due", 64'(irq), 64'd1);
    @(negedge clk); ext = '0; src = 64'(1) << 40;
    @(negedge clk); @(negedge clk);
    check("R6 masked src bit ignored", 64'(irq), 64'd0);
  endtask

  task automatic t_mask_latency();
    @(negedge clk); src = 64'h8;
    @(negedge clk); @(negedge clk);
    check("R4 no enable yet", 64'(irq), 64'd0);
    bus_wr(0, 7, 32'h8);
    check("R4 mask latency early", 64'(irq), 64'd0);
    @(negedge clk); check("R4 mask latency due", 64'(irq), 64'd2);
    bus_wr(0, 7, 32'h0);
    check("R4 clear early", 64'(irq), 64'd2);
    @(negedge clk); check("R4 clear due", 64'(irq), 64'd0);
  endtask

  task automatic t_status_write();
    logic [31:0] d;
    bus_wr(0, 7, 32'h8);
    bus_wr(0, 1, 32'hFFFF_FFFF);
    bus_wr(0, 4, 32'h0);
    bus_rd(0, 1, d); check("R5 status unchanged", 64'(d), 64'h8);
    bus_rd(0, 3, d); check("R5 core0 mask unchanged", 64'(d), 64'h0);
    check("R5 irq unchanged", 64'(irq), 64'd2);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    @(negedge clk); rr = 0; rv = 1; rw = 0; ra = 3'd1;
    @(negedge clk); rv = 0;
    check("R8 rsp valid", 64'(vld), 64'd1);
    check("R8 ready low", 64'(rdy), 64'd0);
    check("R8 data", 64'(rd), 64'h8);
    first = rd;
    src = 64'h0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R8 data held", 64'(rd), 64'(first));
    check("R8 still valid", 64'(vld), 64'd1);
    check("R8 still blocked", 64'(rdy), 64'd0);
    rr = 1;
    @(negedge clk);
    check("R8 drained", 64'(vld), 64'd0);
    check("R8 ready again", 64'(rdy), 64'd1);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    @(negedge clk); n_src = 32'h0000_0F05; n_ext = 4'b0010;
    @(negedge clk); @(negedge clk);
    check("R9 raw expected", 64'(raw32()), 64'h205);
    bus_rd(1, 0, d); check("R9 core0 status", 64'(d), 64'h205);
    bus_rd(1, 2, d); check("R9 core1 status", 64'(d), 64'h205);
    bus_wr(1, 1, 32'h4);
    bus_rd(1, 1, d); check("R9 core0 mask", 64'(d), 64'h4);
    check("R9 core0 irq", 64'(n_irq), 64'd1);
    bus_wr(1, 3, 32'hFFFF_FFFF);
    bus_rd(1, 3, d); check("R7 absent bank reads zero", 64'(d), 64'h0);
    @(negedge clk); @(negedge clk);
    check("R7 core1 irq low", 64'(n_irq), 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_order();
    t_cascade();
    t_mask_indep();
    t_mask_latency();
    t_status_write();
    t_backpressure();
    t_narrow();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule